// File: doc/BRIEF.md
# Bit-serial 32-bit unsigned operation engine

This block is a sequential coprocessor for the 32-bit unsigned operations that are awkward to do in one cycle. A request gives an opcode and two operands, each 64 bits wide so that values too large for 32 bits can reach the block and be rejected. The block then removes the least significant bit of both operands on every cycle. Each removed bit pair updates a running result, and the block stops once both operands are zero. Supported operations are bitwise AND, unsigned less-than, floor of log base 2, population count, XOR, and a split mode that only checks that both operands fit in 32 bits.

All operations share one shift-right datapath and one step counter. The step counter also serves as the 32-bit range check: an operand with any bit set above bit 31 drives the counter past 32, and the operation ends with an error. Each operation ends with a one-cycle done pulse. The result, error flag and step count are held at the outputs until the next operation completes.

Top module: `u32s_engine`

## Requirements
- R1: After reset, done_o, error_o, result_o and steps_o are all 0.
- R2: A start_i accepted in idle loads the operands. Each later cycle shifts both operands right by one while either is nonzero. steps_o reports the larger bit length of the two operands. done_o is high for exactly one cycle, steps_o+2 clock edges after the edge that sampled start_i.
- R3: If either operand has a bit set above bit 31, the operation ends on the 33rd step with error_o=1, steps_o=33, done_o 34 edges after the start edge.
- R4: Opcode 2 returns lhs AND rhs. Both operands zero gives 0.
- R5: Opcode 1 returns 1 when lhs < rhs and 0 otherwise, including when the operands are equal. It never returns 2. Internally the running value is 0 or 1 once decided and 2 while undecided, and a higher differing bit pair overrides a lower one.
- R6: Opcode 3 returns floor(log2(lhs)), which equals steps_o-1. A zero lhs, or a nonzero rhs, gives error_o=1 with steps_o=0 and done_o one edge after the start edge.
- R7: Opcode 4 returns the number of set bits in lhs. A nonzero rhs gives the same immediate error as in R6.
- R8: Opcode 0 returns 0. It raises error_o only through the range check of R3.
- R9: Opcode 5 returns lhs XOR rhs, formed as lhs + rhs - 2*(lhs AND rhs) from the AND accumulation.
- R10: Opcodes 6 and 7 give error_o=1, result_o=0 and steps_o=0, with done_o one edge after the start edge.
- R11: start_i is ignored from the accepting edge until the cycle after done_o. A start during that window neither changes the running operation's outputs nor produces a second done pulse.
- R12: Whenever error_o is 1 at done, result_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a new operation (sampled in idle only) |
| op_i | input | 3 | Opcode: 0 split, 1 less-than, 2 AND, 3 log2, 4 popcount, 5 XOR |
| lhs_i | input | 64 | Left operand |
| rhs_i | input | 64 | Right operand |
| done_o | output | 1 | One-cycle completion pulse |
| error_o | output | 1 | Operation rejected (opcode, operand rule or range) |
| result_o | output | 32 | Operation result |
| steps_o | output | 6 | Number of shift steps taken |

## Verification
The bench sweeps every opcode across all operand pairs below 16, every single-bit position up to bit 40, and a spread of random 32-bit values. It computes each result, step count and latency arithmetically. The corner cases it targets are equal operands for less-than, where a design returning the undecided code or trusting the lowest differing bit would report 2 or the wrong order. It also checks operands exactly at 2^32-1 and 2^32, where an off-by-one counter limit would either reject a valid operand or accept bit 32. Further targets are a zero or misused log2 and popcount request, which a design without the start checks would run to a bogus result, and a start pulse while busy, which a design without the busy guard would let reload the operands mid-run.

// File: rtl/u32s_pkg.sv
package u32s_pkg;
  typedef enum logic [2:0] {
    OP_SPLIT  = 3'd0,
    OP_LT     = 3'd1,
    OP_AND    = 3'd2,
    OP_LOG2   = 3'd3,
    OP_POPCNT = 3'd4,
    OP_XOR    = 3'd5
  } u32s_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } u32s_state_e;

  // running less-than code
  typedef enum logic [1:0] {
    LT_GE  = 2'd0,
    LT_LT  = 2'd1,
    LT_UND = 2'd2
  } u32s_lt_e;
endpackage

// File: rtl/u32s_shifter.sv
module u32s_shifter #(
  parameter int OPND_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic [OPND_W-1:0] lhs_i,
  input  logic [OPND_W-1:0] rhs_i,
  output logic              lhs_lsb_o,
  output logic              rhs_lsb_o,
  output logic              both_zero_o
);
  logic [OPND_W-1:0] in_w [2];
  logic [OPND_W-1:0] opnd_q [2];

  assign in_w[0] = lhs_i;
  assign in_w[1] = rhs_i;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      opnd_q[g] <= '0;
      else if (load_i)  opnd_q[g] <= in_w[g];
      else if (shift_i) opnd_q[g] <= opnd_q[g] >> 1;
    end
  end

  assign lhs_lsb_o   = opnd_q[0][0];
  assign rhs_lsb_o   = opnd_q[1][0];
  assign both_zero_o = ~|opnd_q[0] & ~|opnd_q[1];
endmodule

// File: rtl/u32s_step_ctr.sv
module u32s_step_ctr #(
  parameter int LIMIT = 32,
  parameter int CW    = $clog2(LIMIT + 2)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          inc_i,
  output logic [CW-1:0] cnt_o,
  output logic          at_limit_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (inc_i)   cnt_q <= cnt_q + CW'(1);
  end

  assign cnt_o      = cnt_q;
  // one more step would pass the operand width
  assign at_limit_o = (cnt_q == CW'(LIMIT));
endmodule

// File: rtl/u32s_accum.sv
module u32s_accum
  import u32s_pkg::*;
#(
  parameter int RES_W  = 32,
  parameter int CW     = 6,
  parameter bit XOR_EN = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             step_i,
  input  logic [2:0]       op_i,
  input  logic [RES_W-1:0] lhs_lo_i,
  input  logic [RES_W-1:0] rhs_lo_i,
  input  logic             lhs_bit_i,
  input  logic             rhs_bit_i,
  input  logic [CW-1:0]    cnt_i,
  output logic [RES_W-1:0] result_o
);
  logic [RES_W-1:0] and_q, log_q, pop_q;
  u32s_lt_e         lt_q;
  logic             in_range;
  logic [RES_W-1:0] xor_w;

  assign in_range = (cnt_i < CW'(RES_W));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      and_q <= '0;
      log_q <= '0;
      pop_q <= '0;
      lt_q  <= LT_UND;
    end else if (clear_i) begin
      and_q <= '0;
      log_q <= '0;
      pop_q <= '0;
      lt_q  <= LT_UND;
    end else if (step_i && in_range) begin
      and_q <= and_q | (RES_W'(lhs_bit_i & rhs_bit_i) << cnt_i);
      pop_q <= pop_q + RES_W'(lhs_bit_i);
      if (lhs_bit_i) log_q <= RES_W'(cnt_i);
      // later steps see higher bits, so they override
      if (lhs_bit_i != rhs_bit_i) lt_q <= rhs_bit_i ? LT_LT : LT_GE;
    end
  end

  if (XOR_EN) begin : g_xor
    logic [RES_W-1:0] lhs_lo_q, rhs_lo_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lhs_lo_q <= '0;
        rhs_lo_q <= '0;
      end else if (clear_i) begin
        lhs_lo_q <= lhs_lo_i;
        rhs_lo_q <= rhs_lo_i;
      end
    end
    assign xor_w = lhs_lo_q + rhs_lo_q - (and_q << 1);
  end else begin : g_no_xor
    logic unused_w;
    assign unused_w = ^{lhs_lo_i, rhs_lo_i};
    assign xor_w    = '0;
  end

  always_comb begin
    unique case (op_i)
      OP_LT:     result_o = (lt_q == LT_LT) ? RES_W'(1) : '0;
      OP_AND:    result_o = and_q;
      OP_LOG2:   result_o = log_q;
      OP_POPCNT: result_o = pop_q;
      OP_XOR:    result_o = xor_w;
      default:   result_o = '0;
    endcase
  end
endmodule

// File: rtl/u32s_ctrl.sv
module u32s_ctrl
  import u32s_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic pre_err_i,
  input  logic both_zero_i,
  input  logic at_limit_i,
  output logic load_o,
  output logic step_o,
  output logic capture_o,
  output logic range_err_o,
  output logic busy_o,
  output logic done_o
);
  u32s_state_e state_q, state_d;

  always_comb begin
    state_d     = state_q;
    load_o      = 1'b0;
    step_o      = 1'b0;
    capture_o   = 1'b0;
    range_err_o = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        load_o = 1'b1;
        if (pre_err_i) begin
          capture_o = 1'b1;
          state_d   = ST_FIN;
        end else begin
          state_d   = ST_RUN;
        end
      end
      ST_RUN: begin
        if (both_zero_i) begin
          capture_o = 1'b1;
          state_d   = ST_FIN;
        end else begin
          step_o = 1'b1;
          if (at_limit_i) begin
            range_err_o = 1'b1;
            capture_o   = 1'b1;
            state_d     = ST_FIN;
          end
        end
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = (state_q == ST_FIN);
endmodule

// File: rtl/u32s_engine.sv
module u32s_engine
  import u32s_pkg::*;
#(
  parameter int OPND_W = 64,
  parameter int RES_W  = 32,
  parameter bit XOR_EN = 1'b1,
  localparam int CW    = $clog2(RES_W + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [2:0]        op_i,
  input  logic [OPND_W-1:0] lhs_i,
  input  logic [OPND_W-1:0] rhs_i,
  output logic              done_o,
  output logic              error_o,
  output logic [RES_W-1:0]  result_o,
  output logic [CW-1:0]     steps_o
);
  localparam logic [2:0] OP_TOP = XOR_EN ? 3'(OP_XOR) : 3'(OP_POPCNT);

  logic             load, step, capture, range_err, busy, pre_err;
  logic             lhs_bit, rhs_bit, both_zero, at_limit;
  logic [CW-1:0]    cnt;
  logic [RES_W-1:0] acc_res;
  logic [2:0]       op_q;
  logic             err_q;
  logic [RES_W-1:0] res_q;
  logic [CW-1:0]    steps_q;

  always_comb begin
    pre_err = (op_i > OP_TOP);
    if (op_i == OP_LOG2)   pre_err = (lhs_i == '0) || (rhs_i != '0);
    if (op_i == OP_POPCNT) pre_err = (rhs_i != '0);
  end

  u32s_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .pre_err_i   (pre_err),
    .both_zero_i (both_zero),
    .at_limit_i  (at_limit),
    .load_o      (load),
    .step_o      (step),
    .capture_o   (capture),
    .range_err_o (range_err),
    .busy_o      (busy),
    .done_o      (done_o)
  );

  u32s_shifter #(.OPND_W(OPND_W)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .shift_i     (step),
    .lhs_i       (lhs_i),
    .rhs_i       (rhs_i),
    .lhs_lsb_o   (lhs_bit),
    .rhs_lsb_o   (rhs_bit),
    .both_zero_o (both_zero)
  );

  u32s_step_ctr #(.LIMIT(RES_W), .CW(CW)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (load),
    .inc_i      (step),
    .cnt_o      (cnt),
    .at_limit_o (at_limit)
  );

  u32s_accum #(.RES_W(RES_W), .CW(CW), .XOR_EN(XOR_EN)) u_acc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (load),
    .step_i    (step),
    .op_i      (op_q),
    .lhs_lo_i  (lhs_i[RES_W-1:0]),
    .rhs_lo_i  (rhs_i[RES_W-1:0]),
    .lhs_bit_i (lhs_bit),
    .rhs_bit_i (rhs_bit),
    .cnt_i     (cnt),
    .result_o  (acc_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q    <= '0;
      err_q   <= 1'b0;
      res_q   <= '0;
      steps_q <= '0;
    end else begin
      if (load) op_q <= op_i;
      if (capture) begin
        if (load) begin
          err_q   <= 1'b1;
          res_q   <= '0;
          steps_q <= '0;
        end else if (range_err) begin
          err_q   <= 1'b1;
          res_q   <= '0;
          steps_q <= cnt + CW'(1);
        end else begin
          err_q   <= 1'b0;
          res_q   <= acc_res;
          steps_q <= cnt;
        end
      end
    end
  end

  assign error_o  = err_q;
  assign result_o = res_q;
  assign steps_o  = steps_q;
endmodule

// File: rtl/u32s_engine_chk.sv
module u32s_engine_chk
  import u32s_pkg::*;
#(
  parameter int RES_W = 32,
  parameter int CW    = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             done_o,
  input logic             error_o,
  input logic [RES_W-1:0] result_o,
  input logic [CW-1:0]    steps_o,
  input logic [2:0]       op_q,
  input logic             busy
);
  // R2
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R12
  err_res_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && error_o) |-> (result_o == '0));

  // R5
  lt_binary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !error_o && op_q == OP_LT) |-> (result_o <= RES_W'(1)));

  // R6
  log2_steps_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !error_o && op_q == OP_LOG2) |-> (result_o == RES_W'(steps_o) - RES_W'(1)));

  // R7
  pop_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !error_o && op_q == OP_POPCNT) |-> (result_o <= RES_W'(steps_o)));

  // R3
  steps_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !error_o) |-> (steps_o <= CW'(RES_W)));

  // R3
  range_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && steps_o == CW'(RES_W + 1)) |-> error_o);

  // R11
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> $stable(op_q));
endmodule

bind u32s_engine u32s_engine_chk #(.RES_W(RES_W), .CW(CW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .done_o   (done_o),
  .error_o  (error_o),
  .result_o (result_o),
  .steps_o  (steps_o),
  .op_q     (op_q),
  .busy     (busy)
);

// File: tb/sim_u32s_engine.sv
`timescale 1ns/1ps
module sim_u32s_engine;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [63:0] lhs_i = '0;
  logic [63:0] rhs_i = '0;
  logic        done_o, error_o;
  logic [31:0] result_o;
  logic [5:0]  steps_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk_i = ~clk_i;

  u32s_engine u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .op_i(op_i),
    .lhs_i(lhs_i), .rhs_i(rhs_i), .done_o(done_o), .error_o(error_o),
    .result_o(result_o), .steps_o(steps_o)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int bitlen(input logic [63:0] v);
    int n = 0;
    for (int i = 0; i < 64; i++) if (v[i]) n = i + 1;
    return n;
  endfunction

  function automatic string op_tag(input logic [2:0] op);
    case (op)
      3'd0: return "R8 split";
      3'd1: return "R5 lt";
      3'd2: return "R4 and";
      3'd3: return "R6 log2";
      3'd4: return "R7 popcnt";
      3'd5: return "R9 xor";
      default: return "R10 badop";
    endcase
  endfunction

  task automatic run_op(input logic [2:0] op, input logic [63:0] l, input logic [63:0] r);
    int lat, st;
    bit pre, rng;
    logic [31:0] er;
    @(negedge clk_i);
    start_i = 1'b1; op_i = op; lhs_i = l; rhs_i = r;
    @(posedge clk_i); #1;
    start_i = 1'b0;
    lat = 1;
    while (!done_o && lat < 100) begin
      @(posedge clk_i); #1;
      lat++;
    end
    pre = (op > 3'd5) || (op == 3'd3 && (l == 0 || r != 0)) || (op == 3'd4 && r != 0);
    st  = (bitlen(l) > bitlen(r)) ? bitlen(l) : bitlen(r);
    rng = !pre && st > 32;
    er  = '0;
    if (!pre && !rng) begin
      case (op)
        3'd1: er = (l < r) ? 32'd1 : 32'd0;
        3'd2: er = l[31:0] & r[31:0];
        3'd3: er = 32'(bitlen(l) - 1);
        3'd4: er = 32'($countones(l[31:0]));
        3'd5: er = l[31:0] ^ r[31:0];
        default: er = '0;
      endcase
    end
    if (pre) begin
      check(error_o == 1'b1, op_tag(op), 64'(error_o), 1);
      check(steps_o == 0, op_tag(op), 64'(steps_o), 0);
      check(lat == 1, "R10/R6 early latency", 64'(lat), 1);
      check(result_o == 0, "R12 error result", 64'(result_o), 0);
    end else if (rng) begin
      check(error_o == 1'b1, "R3 range error", 64'(error_o), 1);
      check(steps_o == 6'd33, "R3 range steps", 64'(steps_o), 33);
      check(lat == 34, "R3 range latency", 64'(lat), 34);
      check(result_o == 0, "R12 error result", 64'(result_o), 0);
    end else begin
      check(error_o == 1'b0, op_tag(op), 64'(error_o), 0);
      check(result_o == er, op_tag(op), 64'(result_o), 64'(er));
      check(steps_o == 6'(st), "R2 steps", 64'(steps_o), 64'(st));
      check(lat == st + 2, "R2 latency", 64'(lat), 64'(st + 2));
    end
    @(posedge clk_i); #1;
    check(done_o == 1'b0, "R2 done pulse width", 64'(done_o), 0);
  endtask

  initial begin
    #750000;
    errors++;
    checks++;
    $display("FAIL watchdog expired act=1 exp=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    // R1
    check(done_o == 0 && error_o == 0, "R1 reset flags", {62'd0, done_o, error_o}, 0);
    check(result_o == 0 && steps_o == 0, "R1 reset data", 64'(result_o) | 64'(steps_o), 0);
    @(negedge clk_i); rst_ni = 1'b1;

    // small exhaustive sweep, every opcode
    for (int op = 0; op < 8; op++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          run_op(3'(op), 64'(a), 64'(b));

    // single-bit positions across the range boundary
    for (int i = 0; i < 41; i++) begin
      run_op(3'd3, 64'd1 << i, 64'd0);
      run_op(3'd4, (64'd1 << i) | 64'd5, 64'd0);
      run_op(3'd0, 64'd0, 64'd1 << i);
      run_op(3'd1, 64'd1 << i, 64'd3);
      run_op(3'd2, (64'd1 << i) | 64'hF0, 64'hFFFF_FFFF);
      run_op(3'd5, 64'hA5A5_A5A5, 64'd1 << i);
    end

    // boundaries
    run_op(3'd0, 64'hFFFF_FFFF, 64'hFFFF_FFFF);           // R8 largest legal
    run_op(3'd0, 64'h1_0000_0000, 64'd0);                 // R3 first illegal
    run_op(3'd1, 64'hFFFF_FFFF, 64'hFFFF_FFFF);           // R5 equal -> 0
    run_op(3'd1, 64'h8000_0000, 64'h7FFF_FFFF);           // R5 top bit decides
    run_op(3'd1, 64'h7FFF_FFFF, 64'h8000_0000);
    run_op(3'd2, 64'hFFFF_FFFF, 64'hFFFF_FFFF);           // R4
    run_op(3'd3, 64'hFFFF_FFFF, 64'd0);                   // R6
    run_op(3'd3, 64'd8, 64'd1);                           // R6 rhs nonzero
    run_op(3'd4, 64'hFFFF_FFFF, 64'd0);                   // R7
    run_op(3'd5, 64'hFFFF_FFFF, 64'h1234_5678);           // R9

    // random 32-bit operands
    for (int k = 0; k < 60; k++)
      for (int op = 0; op < 6; op++) begin
        logic [63:0] a, b;
        a = 64'($urandom);
        b = (op == 3 || op == 4) ? 64'd0 : 64'($urandom);
        run_op(3'(op), a, b);
      end

    // R11 start while busy is ignored
    begin
      int dones = 0;
      @(negedge clk_i);
      start_i = 1'b1; op_i = 3'd2; lhs_i = 64'hFF; rhs_i = 64'h3C;
      @(negedge clk_i);
      op_i = 3'd7; lhs_i = 64'h1; rhs_i = 64'h1;
      @(negedge clk_i);
      start_i = 1'b0;
      for (int c = 0; c < 20; c++) begin
        @(posedge clk_i); #1;
        if (done_o) begin
          dones++;
          check(error_o == 0, "R11 busy start error", 64'(error_o), 0);
          check(result_o == 32'h3C, "R11 busy start result", 64'(result_o), 64'h3C);
          check(steps_o == 6'd8, "R11 busy start steps", 64'(steps_o), 8);
        end
      end
      check(dones == 1, "R11 done count", 64'(dones), 1);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule